// File: doc/BRIEF.md
# Interrupt Steering and Grouping Unit

This block collects a parameterised number of interrupt request lines, a multiple of 32 up to 512, and presents them in 32-bit register words. Each input can be enabled or blocked by a mask bit and forced active by a software set bit. The resulting status bits are folded into groups of 64 inputs, and each group drives one interrupt line. A one-hot channel register picks which output channel receives the group lines. Every channel has its own bank of group lines, and a channel whose bit is clear keeps its lines low.

Software reaches the block through a simple single-cycle request bus with byte addresses and registered read data. The register words are stored in reverse order: the highest-numbered word holds inputs 0 to 31. The mask, set and status banks sit back to back, and their spacing grows with the number of words, so the same driver code works for every input count.

Top module: `irqs_top`

## Requirements
- R1: After reset the channel register, every mask word and every set word read as 0, and all `irq_o` lines are low whatever `irq_i` carries.
- R2: The channel register sits at byte offset 0x0. Bit c (c < NUM_CH) enables channel c, and bits at or above NUM_CH read as 0. Output line `irq_o[c*NUM_GRP+g]` carries group g for channel c, and it is low whenever bit c is clear.
- R3: Input i appears in register word WORDS-1-i/32 at bit i%32, where WORDS = NUM_IN/32.
- R4: Mask word k is at byte offset 0x4+4k, set word k at 0x4+4*WORDS+4k, and status word k at 0x4+8*WORDS+4k.
- R5: A mask bit of 1 passes its input and a mask bit of 0 blocks it from both the status bit and the output lines.
- R6: Set words are readable and writable. A status bit equals (live input OR set bit) AND mask bit.
- R7: There are NUM_GRP = ceil(NUM_IN/64) groups. Group g is high when any status bit of inputs 64g to 64g+63 is 1, and the output lines follow input and register changes in the same cycle, with no register stage.
- R8: Reads from offsets that are unmapped or not word aligned return 0. Writes to such offsets, and writes to the status bank, change no register.
- R9: The read data appears in the cycle after the read request and holds until the next read request.
- R10: With NUM_IN=32 each bank has a single word (mask 0x4, set 0x8, status 0xC), offset 0x10 is unmapped, and each channel has a single output line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | NUM_IN | Interrupt request inputs, bit i is input i |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | NUM_CH*NUM_GRP | Group lines, index c*NUM_GRP+g |

## Verification
Two paths can act on the same status word in the same cycle: a live input that rises, and a software write to a set word. The bench raises input 70 at the same clock edge as a set-word write that forces input 5. Both groups must then be high on the selected channel, and the status words must show both bits at their reversed word positions. A sweep over every single input, and then over every set bit, compares each status word and each group line with values the bench computes from the word-index formula.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  typedef enum logic [2:0] {
    BK_NONE,
    BK_CTRL,
    BK_MASK,
    BK_SET,
    BK_STAT
  } bank_e;

  function automatic int grp_count(input int n_in);
    return (n_in + 63) / 64;
  endfunction

endpackage

// File: rtl/irqs_decode.sv
module irqs_decode
  import irqs_pkg::*;
#(
  parameter int WORDS  = 3,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output bank_e             bank_o,
  output logic [IDX_W-1:0]  idx_o
);

  always_comb begin
    int wa;
    wa     = int'(addr_i[ADDR_W-1:2]);
    bank_o = BK_NONE;
    idx_o  = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (wa == 0) begin
        bank_o = BK_CTRL;
      end else if (wa <= WORDS) begin
        bank_o = BK_MASK;
        idx_o  = IDX_W'(wa - 1);
      end else if (wa <= 2 * WORDS) begin
        bank_o = BK_SET;
        idx_o  = IDX_W'(wa - 1 - WORDS);
      end else if (wa <= 3 * WORDS) begin
        bank_o = BK_STAT;
        idx_o  = IDX_W'(wa - 1 - 2 * WORDS);
      end
    end
  end

endmodule

// File: rtl/irqs_group.sv
module irqs_group #(
  parameter int NUM_IN  = 96,
  parameter int NUM_GRP = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IN-1:0]  stat_i,
  output logic [NUM_GRP-1:0] grp_o
);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LO = 64 * g;
    localparam int SZ = ((NUM_IN - LO) > 64) ? 64 : (NUM_IN - LO);
    assign grp_o[g] = |stat_i[LO +: SZ];
  end

  AST_GRP_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grp_o) |-> (|stat_i)); // R7

endmodule

// File: rtl/irqs_top.sv
module irqs_top
  import irqs_pkg::*;
#(
  parameter int NUM_IN  = 96,
  parameter int NUM_CH  = 2,
  parameter int ADDR_W  = 8,
  localparam int NUM_GRP = grp_count(NUM_IN)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_IN-1:0]         irq_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [NUM_CH*NUM_GRP-1:0] irq_o
);

  localparam int WORDS = NUM_IN / 32;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  bank_e            bank;
  logic [IDX_W-1:0] idx;

  irqs_decode #(.WORDS(WORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr_i (addr_i),
    .bank_o (bank),
    .idx_o  (idx)
  );

  logic [NUM_CH-1:0]      chan_q, chan_d;
  logic [WORDS-1:0][31:0] mask_q, mask_d;
  logic [WORDS-1:0][31:0] set_q, set_d;
  logic [31:0]            rdata_q, rdata_d;
  logic [WORDS-1:0][31:0] stat_w;
  logic [NUM_IN-1:0]      stat_flat;
  logic                   wr_en, rd_en;

  assign wr_en = req_i & we_i;
  assign rd_en = req_i & ~we_i;

  // reversed word order: word k holds inputs (WORDS-1-k)*32 ..
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    assign stat_w[k] = (irq_i[(WORDS-1-k)*32 +: 32] | set_q[k]) & mask_q[k];
    assign stat_flat[(WORDS-1-k)*32 +: 32] = stat_w[k];
  end

  always_comb begin
    chan_d  = chan_q;
    mask_d  = mask_q;
    set_d   = set_q;
    rdata_d = rdata_q;
    if (wr_en) begin
      case (bank)
        BK_CTRL: chan_d      = wdata_i[NUM_CH-1:0];
        BK_MASK: mask_d[idx] = wdata_i;
        BK_SET:  set_d[idx]  = wdata_i;
        default: ;
      endcase
    end
    if (rd_en) begin
      case (bank)
        BK_CTRL: rdata_d = 32'(chan_q);
        BK_MASK: rdata_d = mask_q[idx];
        BK_SET:  rdata_d = set_q[idx];
        BK_STAT: rdata_d = stat_w[idx];
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      mask_q  <= '0;
      set_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en) begin
        chan_q <= chan_d;
        mask_q <= mask_d;
        set_q  <= set_d;
      end
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  logic [NUM_GRP-1:0] grp;

  irqs_group #(.NUM_IN(NUM_IN), .NUM_GRP(NUM_GRP)) u_grp (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .stat_i (stat_flat),
    .grp_o  (grp)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_line
      assign irq_o[c*NUM_GRP+g] = chan_q[c] & grp[g];
    end
  end

  logic mask_any;
  assign mask_any = |mask_q;

  AST_NO_CHAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (chan_q == '0) |-> (irq_o == '0)); // R2
  AST_MASK_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mask_any) |-> (irq_o == '0)); // R5
  AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en && bank == BK_NONE) |=> (rdata_o == '0)); // R8
  AST_STAT_WR_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en && bank == BK_STAT) |=> ($stable(set_q) && $stable(mask_q) && $stable(chan_q))); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!rd_en) |=> $stable(rdata_o)); // R9

endmodule

// File: tb/irqs_top_tb_top.sv
module irqs_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [95:0] irq96;
  logic [31:0] irq32;
  logic        req0, req1, we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata0, rdata1;
  logic [3:0]  out96;
  logic [0:0]  out32;

  int total = 0;
  int bad   = 0;

  logic [31:0] emask [3];
  logic [31:0] eset  [3];
  logic [1:0]  echan;

  always #5 clk = ~clk;

  irqs_top #(.NUM_IN(96), .NUM_CH(2), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq96), .req_i(req0), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0), .irq_o(out96)
  );

  irqs_top #(.NUM_IN(32), .NUM_CH(1), .ADDR_W(8)) dut32_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq32), .req_i(req1), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .irq_o(out32)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    if (sel == 0) req0 = 1'b1; else req1 = 1'b1;
    @(negedge clk);
    req0 = 1'b0; req1 = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int sel, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    if (sel == 0) req0 = 1'b1; else req1 = 1'b1;
    @(negedge clk);
    req0 = 1'b0; req1 = 1'b0;
    d = (sel == 0) ? rdata0 : rdata1;
  endtask

  // model of the 96-input instance
  function automatic logic [31:0] exp_stat(input int k);
    return (irq96[(2-k)*32 +: 32] | eset[k]) & emask[k];
  endfunction

  function automatic logic [3:0] exp_out();
    logic [3:0] e;
    logic [1:0] gany;
    gany = 2'b00;
    for (int i = 0; i < 96; i++) begin
      logic [31:0] w;
      w = exp_stat(2 - i / 32);
      if (w[i % 32]) gany[i / 64] = 1'b1;
    end
    for (int c = 0; c < 2; c++)
      for (int g = 0; g < 2; g++)
        e[c*2+g] = echan[c] & gany[g];
    return e;
  endfunction

  task automatic w96_mask(input int k, input logic [31:0] d);
    wr(0, 8'(4 + 4*k), d); emask[k] = d;
  endtask

  task automatic w96_set(input int k, input logic [31:0] d);
    wr(0, 8'(16 + 4*k), d); eset[k] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; req0 = 1'b0; req1 = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    irq96 = '1; irq32 = '1;
    for (int k = 0; k < 3; k++) begin emask[k] = '0; eset[k] = '0; end
    echan = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(0, 8'h00, r); chk("R1 ctrl", r, 32'h0);
    for (int k = 0; k < 3; k++) begin
      rd(0, 8'(4 + 4*k), r);  chk("R1 mask", r, 32'h0);
      rd(0, 8'(16 + 4*k), r); chk("R1 set", r, 32'h0);
    end
    chk("R1 out96", 32'(out96), 32'h0);
    chk("R1 out32", 32'(out32), 32'h0);

    // R2: channel register width
    wr(0, 8'h00, 32'hFFFF_FFFF); rd(0, 8'h00, r); chk("R2 ctrl readback", r, 32'h3);
    wr(0, 8'h00, 32'h0); echan = 2'b00;
    for (int k = 0; k < 3; k++) w96_mask(k, 32'hFFFF_FFFF);
    #1 chk("R2 no channel quiet", 32'(out96), 32'h0);
    wr(0, 8'h00, 32'h1); echan = 2'b01;

    // R3/R4/R7: single-input sweep
    for (int i = 0; i < 96; i++) begin
      int kw;
      @(negedge clk);
      irq96 = '0; irq96[i] = 1'b1;
      kw = 2 - i / 32;
      rd(0, 8'(28 + 4*kw), r);
      chk("R3 status word position", r, 32'(1) << (i % 32));
      chk("R7 group lines", 32'(out96), 32'(exp_out()));
    end

    // R2: route to channel 1
    wr(0, 8'h00, 32'h2); echan = 2'b10;
    @(negedge clk); irq96 = '0; irq96[80] = 1'b1;
    #1 chk("R2 channel one routing", 32'(out96), 32'h8);
    wr(0, 8'h00, 32'h1); echan = 2'b01;

    // R5: partial masks
    @(negedge clk); irq96 = '1;
    for (int k = 0; k < 3; k++) w96_mask(k, 32'h0000_FFFF);
    for (int k = 0; k < 3; k++) begin
      rd(0, 8'(28 + 4*k), r); chk("R5 masked status", r, 32'h0000_FFFF);
    end
    w96_mask(0, 32'h0);
    @(negedge clk); irq96 = '0; irq96[70] = 1'b1; irq96[20] = 1'b1;
    #1 chk("R5 masked input blocked", 32'(out96), 32'(exp_out()));
    for (int k = 0; k < 3; k++) w96_mask(k, 32'hFFFF_FFFF);

    // R6/R7: set-bit sweep with inputs idle
    @(negedge clk); irq96 = '0;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 32; b++) begin
        w96_set(k, 32'(1) << b);
        rd(0, 8'(16 + 4*k), r); chk("R6 set readback", r, 32'(1) << b);
        chk("R6 set drives group", 32'(out96), 32'(exp_out()));
      end
      w96_set(k, 32'h0);
    end
    w96_set(1, 32'h0000_0100); w96_mask(1, 32'h0);
    rd(0, 8'(28 + 4), r); chk("R6 set gated by mask", r, 32'h0);
    chk("R6 masked set no output", 32'(out96), 32'h0);
    w96_mask(1, 32'hFFFF_FFFF); w96_set(1, 32'h0);

    // R4: offsets of banks
    w96_mask(2, 32'hA5A5_0F0F);
    rd(0, 8'h0C, r); chk("R4 mask word 2 offset", r, 32'hA5A5_0F0F);
    w96_set(2, 32'h0000_0003);
    rd(0, 8'h18, r); chk("R4 set word 2 offset", r, 32'h0000_0003);
    rd(0, 8'h24, r); chk("R4 status word 2 offset", r, 32'h0000_0003);
    w96_mask(2, 32'hFFFF_FFFF); w96_set(2, 32'h0);

    // R8: unmapped and misaligned accesses
    rd(0, 8'h28, r); chk("R8 unmapped read", r, 32'h0);
    rd(0, 8'h05, r); chk("R8 misaligned read", r, 32'h0);
    rd(0, 8'hFC, r); chk("R8 high read", r, 32'h0);
    wr(0, 8'h28, 32'h1234_5678);
    wr(0, 8'h05, 32'h0);
    wr(0, 8'h11, 32'hFFFF_FFFF);
    wr(0, 8'h1C, 32'hFFFF_FFFF);
    rd(0, 8'h04, r); chk("R8 mask untouched", r, 32'hFFFF_FFFF);
    rd(0, 8'h10, r); chk("R8 set untouched", r, 32'h0);
    rd(0, 8'h1C, r); chk("R8 status write ignored", r, 32'h0);
    rd(0, 8'h00, r); chk("R8 ctrl untouched", r, 32'h1);
    chk("R8 outputs idle", 32'(out96), 32'h0);

    // R9: read data holds between reads
    w96_set(0, 32'h0000_00F0);
    rd(0, 8'h10, r);
    @(negedge clk); chk("R9 rdata held", rdata0, 32'h0000_00F0);
    w96_set(0, 32'h0);

    // R6/R7: input and set write in the same cycle
    @(negedge clk);
    irq96 = '0; irq96[70] = 1'b1;
    addr = 8'h18; wdata = 32'h0000_0020; we = 1'b1; req0 = 1'b1;
    @(negedge clk);
    req0 = 1'b0; we = 1'b0; eset[2] = 32'h0000_0020;
    chk("R7 same cycle both groups", 32'(out96), 32'h3);
    rd(0, 8'h24, r); chk("R6 same cycle word 2", r, 32'h0000_0020);
    rd(0, 8'h1C, r); chk("R6 same cycle word 0", r, 32'h0000_0040);
    w96_set(2, 32'h0);

    // R10: single-word configuration
    @(negedge clk); irq32 = '0;
    wr(1, 8'h00, 32'h1);
    wr(1, 8'h04, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); irq32 = 32'(1) << i;
      rd(1, 8'h0C, r); chk("R10 status", r, 32'(1) << i);
      chk("R10 output", 32'(out32), 32'h1);
    end
    @(negedge clk); irq32 = '0;
    wr(1, 8'h08, 32'h8000_0000);
    rd(1, 8'h08, r); chk("R10 set offset", r, 32'h8000_0000);
    chk("R10 set output", 32'(out32), 32'h1);
    rd(1, 8'h10, r); chk("R10 unmapped", r, 32'h0);
    wr(1, 8'h08, 32'h0);
    #1 chk("R10 output clear", 32'(out32), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule